// File: doc/BRIEF.md
# CCD Binning Readout Sequencer

This block times the readout of a CCD sensor. It issues single-cycle vertical row-shift strobes, which move frame charge down into the serial register, and horizontal pixel-shift strobes, which move serial-register charge into the output node. After each horizontal shift on a line that is kept, it raises a convert strobe for an external ADC. Vertical binning happens on the chip. The sequencer issues several row shifts before a line scan, so the charge of those rows adds up in the serial register.

Four readout modes are supported. Full frame reads the sensor in lines of a programmable number of binned rows. Single-track bins one band of rows into one line. Multi-track does the same for several bands in ascending order. Full vertical binning shifts the whole frame into the serial register and reads it as one line. In the track modes, rows that lie before a band are still shifted down so that the band can be reached. Their charge is then cleared by a dump scan that produces no conversions. A settling gap count puts idle cycles after every strobe. A bad configuration is refused at start.

Top module: `ccd_readout_seq`

## Requirements
- R1: Mode code 0 (full frame) reads the sensor as lines. Each line issues min(vbin, rows left) vertical strobes, then a line scan with conversions, until all sensor rows are shifted.
- R2: Every line scan, kept or dumped, issues exactly `width` horizontal strobes. `col_idx_o` shows 0, 1, ..., width-1 in the cycle of each horizontal strobe.
- R3: On a kept line, every horizontal strobe is followed by exactly one convert strobe, gap+1 cycles later and before the next horizontal strobe.
- R4: Strobes are one cycle wide, at most one strobe is high in any cycle, and the smallest spacing between consecutive strobes equals gap+1 cycles.
- R5: Mode code 1 (single-track) uses track entry 0. The rows below the track start are shifted and then dumped. The track's rows are then binned into one kept line, and the run ends.
- R6: Mode code 2 (multi-track) processes the first `ntracks` entries in index order, each one as in R5. No dump scan appears when a track starts on the row right after the previous one.
- R7: A dump scan issues its horizontal strobes with no convert strobe.
- R8: Mode code 3 (full vertical binning) shifts all sensor rows and reads one kept line, whatever the vbin setting. `row_idx_o` counts the rows shifted so far in the run.
- R9: Start is taken only when idle. `busy_o` rises the cycle after an accepted start and stays high through the last strobe. `done_o` pulses for one cycle as busy falls. A start while busy has no effect.
- R10: A start with an invalid configuration sets `cfg_err_o`, leaves `busy_o` low and issues no strobe. Invalid means tracks overlapping or out of order, a track past the sensor height, a zero-height track, ntracks below 2 in multi-track, or a zero width or height. The next valid start clears `cfg_err_o`.
- R11: After reset, all strobes, flags and indices are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start a readout run |
| cfg_mode_i | input | 2 | 0 full frame, 1 single-track, 2 multi-track, 3 full vertical binning |
| cfg_width_i | input | COL_W | Columns per line |
| cfg_height_i | input | ROW_W | Sensor rows |
| cfg_vbin_i | input | ROW_W | Rows binned per line in full frame mode |
| cfg_gap_i | input | GAP_W | Idle cycles after each strobe |
| cfg_ntracks_i | input | $clog2(NTRK+1) | Tracks used in multi-track mode |
| trk_start_i | input | NTRK*ROW_W | First row of each track, entry i at bits [i*ROW_W +: ROW_W] |
| trk_height_i | input | NTRK*ROW_W | Row count of each track, same packing |
| vshift_o | output | 1 | Vertical row-shift strobe |
| hshift_o | output | 1 | Horizontal pixel-shift strobe |
| convert_o | output | 1 | ADC convert strobe |
| row_idx_o | output | ROW_W | Rows shifted so far in the run |
| col_idx_o | output | COL_W | Column of the latest horizontal strobe |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | One-cycle end-of-run pulse |
| cfg_err_o | output | 1 | Last start was refused |

## Verification
The bench builds the block with ROW_W=5, COL_W=4, NTRK=3 and GAP_W=3. At that size the whole track table can be filled, and a band can end exactly on the last sensor row. A full-frame run ends on a partial line. Small gap values let the bench measure strobe spacing both back-to-back and with settling cycles, and the dump-then-read order of every track stays short enough to compare group by group.

// File: rtl/ccd_seq_pkg.sv
package ccd_seq_pkg;
  typedef enum logic [1:0] {
    MODE_FULL   = 2'd0,
    MODE_SINGLE = 2'd1,
    MODE_MULTI  = 2'd2,
    MODE_FVB    = 2'd3
  } rd_mode_e;

  typedef enum logic [2:0] {
    LS_IDLE, LS_VSH, LS_HSH, LS_CNV, LS_WAIT, LS_END
  } line_st_e;

  typedef enum logic [1:0] {
    TS_IDLE, TS_PLAN, TS_RUN, TS_FIN
  } top_st_e;
endpackage

// File: rtl/ccd_seq_cfg_check.sv
module ccd_seq_cfg_check
  import ccd_seq_pkg::*;
#(
  parameter int ROW_W = 10,
  parameter int COL_W = 10,
  parameter int NTRK  = 4,
  parameter int TW    = $clog2(NTRK + 1)
) (
  input  logic [1:0]            mode_i,
  input  logic [COL_W-1:0]      width_i,
  input  logic [ROW_W-1:0]      height_i,
  input  logic [ROW_W-1:0]      vbin_i,
  input  logic [TW-1:0]         ntracks_i,
  input  logic [NTRK*ROW_W-1:0] ts_i,
  input  logic [NTRK*ROW_W-1:0] th_i,
  output logic                  bad_o
);
  logic            trk_mode;
  logic [TW-1:0]   ntr;
  logic [ROW_W:0]  trk_end [NTRK];
  logic [NTRK-1:0] trk_bad;
  logic            geo_bad;

  assign trk_mode = (mode_i == MODE_SINGLE) || (mode_i == MODE_MULTI);
  assign ntr      = (mode_i == MODE_SINGLE) ? TW'(1) : ntracks_i;

  for (genvar g = 0; g < NTRK; g++) begin : g_trk
    logic [ROW_W-1:0] s, h;
    logic             en;
    assign s  = ts_i[g*ROW_W +: ROW_W];
    assign h  = th_i[g*ROW_W +: ROW_W];
    assign en = trk_mode && (int'(ntr) > g);
    assign trk_end[g] = {1'b0, s} + {1'b0, h};
    if (g == 0) begin : g_first
      assign trk_bad[g] = en && ((h == '0) || (trk_end[g] > {1'b0, height_i}));
    end else begin : g_next
      assign trk_bad[g] = en && ((h == '0) || (trk_end[g] > {1'b0, height_i}) ||
                                 ({1'b0, s} < trk_end[g-1]));
    end
  end

  always_comb begin
    geo_bad = (width_i == '0) || (height_i == '0);
    if (mode_i == MODE_FULL && vbin_i == '0) geo_bad = 1'b1;
    if (mode_i == MODE_MULTI && (int'(ntracks_i) < 2 || int'(ntracks_i) > NTRK))
      geo_bad = 1'b1;
  end

  assign bad_o = geo_bad || (|trk_bad);
endmodule

// File: rtl/ccd_seq_planner.sv
module ccd_seq_planner
  import ccd_seq_pkg::*;
#(
  parameter int ROW_W = 10,
  parameter int NTRK  = 4,
  parameter int TW    = $clog2(NTRK + 1)
) (
  input  logic [1:0]            mode_i,
  input  logic [ROW_W-1:0]      row_i,
  input  logic [TW-1:0]         tidx_i,
  input  logic [ROW_W-1:0]      height_i,
  input  logic [ROW_W-1:0]      vbin_i,
  input  logic [TW-1:0]         ntracks_i,
  input  logic [NTRK*ROW_W-1:0] ts_i,
  input  logic [NTRK*ROW_W-1:0] th_i,
  output logic                  fin_o,
  output logic [ROW_W-1:0]      vcnt_o,
  output logic                  read_o,
  output logic                  adv_o
);
  logic [ROW_W-1:0] ts_a [NTRK];
  logic [ROW_W-1:0] th_a [NTRK];
  logic [ROW_W:0]   rem;
  logic [TW-1:0]    ntr;
  logic [ROW_W-1:0] cur_s, cur_h;

  for (genvar g = 0; g < NTRK; g++) begin : g_unpack
    assign ts_a[g] = ts_i[g*ROW_W +: ROW_W];
    assign th_a[g] = th_i[g*ROW_W +: ROW_W];
  end

  assign rem = {1'b0, height_i} - {1'b0, row_i};
  assign ntr = (mode_i == MODE_SINGLE) ? TW'(1) : ntracks_i;

  always_comb begin
    cur_s = '0;
    cur_h = '0;
    for (int i = 0; i < NTRK; i++) begin
      if (int'(tidx_i) == i) begin
        cur_s = ts_a[i];
        cur_h = th_a[i];
      end
    end
  end

  always_comb begin
    fin_o  = 1'b0;
    vcnt_o = '0;
    read_o = 1'b1;
    adv_o  = 1'b0;
    case (mode_i)
      MODE_FULL: begin
        fin_o  = (rem == '0);
        vcnt_o = ({1'b0, vbin_i} < rem) ? vbin_i : rem[ROW_W-1:0];
      end
      MODE_FVB: begin
        fin_o  = (rem == '0);
        vcnt_o = rem[ROW_W-1:0];
      end
      default: begin
        fin_o = (tidx_i >= ntr);
        if (row_i < cur_s) begin
          vcnt_o = cur_s - row_i;
          read_o = 1'b0;
        end else begin
          vcnt_o = cur_h;
          adv_o  = 1'b1;
        end
      end
    endcase
  end
endmodule

// File: rtl/ccd_seq_line.sv
module ccd_seq_line
  import ccd_seq_pkg::*;
#(
  parameter int ROW_W = 10,
  parameter int COL_W = 10,
  parameter int GAP_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             go_i,
  input  logic [ROW_W-1:0] vcnt_i,
  input  logic             read_i,
  input  logic [COL_W-1:0] width_i,
  input  logic [GAP_W-1:0] gap_i,
  output logic             vshift_o,
  output logic             hshift_o,
  output logic             convert_o,
  output logic [COL_W-1:0] col_o,
  output logic             seg_done_o
);
  line_st_e         st, ret, nxt;
  logic [ROW_W-1:0] vleft;
  logic [COL_W-1:0] col;
  logic [GAP_W-1:0] wcnt;
  logic             read_q;
  logic             strobe_st;

  assign strobe_st = (st == LS_VSH) || (st == LS_HSH) || (st == LS_CNV);

  always_comb begin
    nxt = LS_IDLE;
    case (st)
      LS_VSH:  nxt = (vleft == ROW_W'(1)) ? LS_HSH : LS_VSH;
      LS_HSH:  nxt = read_q ? LS_CNV :
                     ((col == width_i - COL_W'(1)) ? LS_END : LS_HSH);
      LS_CNV:  nxt = (col == width_i) ? LS_END : LS_HSH;
      default: nxt = LS_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= LS_IDLE;
      ret        <= LS_IDLE;
      vleft      <= '0;
      col        <= '0;
      wcnt       <= '0;
      read_q     <= 1'b0;
      vshift_o   <= 1'b0;
      hshift_o   <= 1'b0;
      convert_o  <= 1'b0;
      col_o      <= '0;
      seg_done_o <= 1'b0;
    end else begin
      vshift_o   <= 1'b0;
      hshift_o   <= 1'b0;
      convert_o  <= 1'b0;
      seg_done_o <= 1'b0;
      case (st)
        LS_IDLE: if (go_i) begin
          vleft  <= vcnt_i;
          read_q <= read_i;
          col    <= '0;
          st     <= (vcnt_i == '0) ? LS_HSH : LS_VSH;
        end
        LS_VSH: begin
          vshift_o <= 1'b1;
          vleft    <= vleft - ROW_W'(1);
        end
        LS_HSH: begin
          hshift_o <= 1'b1;
          col_o    <= col;
          col      <= col + COL_W'(1);
        end
        LS_CNV: convert_o <= 1'b1;
        LS_WAIT: begin
          wcnt <= wcnt - GAP_W'(1);
          if (wcnt == GAP_W'(1)) st <= ret;
        end
        LS_END: begin
          seg_done_o <= 1'b1;
          st         <= LS_IDLE;
        end
        default: st <= LS_IDLE;
      endcase
      if (strobe_st) begin
        if (gap_i == '0) begin
          st <= nxt;
        end else begin
          wcnt <= gap_i;
          ret  <= nxt;
          st   <= LS_WAIT;
        end
      end
    end
  end

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (rst)
    $countones({vshift_o, hshift_o, convert_o}) <= 1); // R4
  AST_CONV_NEXT: assert property (@(posedge clk) disable iff (rst)
    (hshift_o && read_q && gap_i == '0) |=> convert_o); // R3
  AST_DUMP_NO_CONV: assert property (@(posedge clk) disable iff (rst)
    (!read_q && st != LS_IDLE) |-> !convert_o); // R7
endmodule

// File: rtl/ccd_readout_seq.sv
module ccd_readout_seq
  import ccd_seq_pkg::*;
#(
  parameter int ROW_W = 10,
  parameter int COL_W = 10,
  parameter int NTRK  = 4,
  parameter int GAP_W = 4
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          start_i,
  input  logic [1:0]                    cfg_mode_i,
  input  logic [COL_W-1:0]              cfg_width_i,
  input  logic [ROW_W-1:0]              cfg_height_i,
  input  logic [ROW_W-1:0]              cfg_vbin_i,
  input  logic [GAP_W-1:0]              cfg_gap_i,
  input  logic [$clog2(NTRK+1)-1:0]     cfg_ntracks_i,
  input  logic [NTRK*ROW_W-1:0]         trk_start_i,
  input  logic [NTRK*ROW_W-1:0]         trk_height_i,
  output logic                          vshift_o,
  output logic                          hshift_o,
  output logic                          convert_o,
  output logic [ROW_W-1:0]              row_idx_o,
  output logic [COL_W-1:0]              col_idx_o,
  output logic                          busy_o,
  output logic                          done_o,
  output logic                          cfg_err_o
);
  localparam int TW = $clog2(NTRK + 1);

  top_st_e          st;
  logic [ROW_W-1:0] row;
  logic [TW-1:0]    tidx;
  logic             cfg_bad;
  logic             pl_fin, pl_read, pl_adv;
  logic [ROW_W-1:0] pl_vcnt;
  logic             go;
  logic             seg_done;

  ccd_seq_cfg_check #(.ROW_W(ROW_W), .COL_W(COL_W), .NTRK(NTRK), .TW(TW)) chk_i (
    .mode_i(cfg_mode_i), .width_i(cfg_width_i), .height_i(cfg_height_i),
    .vbin_i(cfg_vbin_i), .ntracks_i(cfg_ntracks_i), .ts_i(trk_start_i),
    .th_i(trk_height_i), .bad_o(cfg_bad)
  );

  ccd_seq_planner #(.ROW_W(ROW_W), .NTRK(NTRK), .TW(TW)) plan_i (
    .mode_i(cfg_mode_i), .row_i(row), .tidx_i(tidx), .height_i(cfg_height_i),
    .vbin_i(cfg_vbin_i), .ntracks_i(cfg_ntracks_i), .ts_i(trk_start_i),
    .th_i(trk_height_i), .fin_o(pl_fin), .vcnt_o(pl_vcnt), .read_o(pl_read),
    .adv_o(pl_adv)
  );

  logic [ROW_W-1:0] vcnt_q;
  logic             read_q;

  ccd_seq_line #(.ROW_W(ROW_W), .COL_W(COL_W), .GAP_W(GAP_W)) line_i (
    .clk(clk), .rst(rst), .go_i(go), .vcnt_i(vcnt_q), .read_i(read_q),
    .width_i(cfg_width_i), .gap_i(cfg_gap_i), .vshift_o(vshift_o),
    .hshift_o(hshift_o), .convert_o(convert_o), .col_o(col_idx_o),
    .seg_done_o(seg_done)
  );

  assign row_idx_o = row;

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= TS_IDLE;
      row       <= '0;
      tidx      <= '0;
      go        <= 1'b0;
      vcnt_q    <= '0;
      read_q    <= 1'b0;
      busy_o    <= 1'b0;
      done_o    <= 1'b0;
      cfg_err_o <= 1'b0;
    end else begin
      go     <= 1'b0;
      done_o <= 1'b0;
      if (vshift_o) row <= row + ROW_W'(1);
      case (st)
        TS_IDLE: if (start_i) begin
          if (cfg_bad) begin
            cfg_err_o <= 1'b1;
          end else begin
            cfg_err_o <= 1'b0;
            busy_o    <= 1'b1;
            row       <= '0;
            tidx      <= '0;
            st        <= TS_PLAN;
          end
        end
        TS_PLAN: begin
          if (pl_fin) begin
            st <= TS_FIN;
          end else begin
            vcnt_q <= pl_vcnt;
            read_q <= pl_read;
            go     <= 1'b1;
            tidx   <= tidx + TW'(pl_adv);
            st     <= TS_RUN;
          end
        end
        TS_RUN: if (seg_done) st <= TS_PLAN;
        TS_FIN: begin
          busy_o <= 1'b0;
          done_o <= 1'b1;
          st     <= TS_IDLE;
        end
        default: st <= TS_IDLE;
      endcase
    end
  end

  AST_DONE_ONE: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o); // R9
  AST_QUIET_IDLE: assert property (@(posedge clk) disable iff (rst)
    !busy_o |-> !(vshift_o || hshift_o || convert_o)); // R9
  AST_ERR_IDLE: assert property (@(posedge clk) disable iff (rst)
    cfg_err_o |-> !busy_o); // R10
  AST_BUSY_START: assert property (@(posedge clk) disable iff (rst)
    $rose(busy_o) |-> $past(start_i)); // R9
  AST_DONE_BUSY: assert property (@(posedge clk) disable iff (rst)
    done_o |-> !busy_o && $past(busy_o)); // R9
endmodule

// File: tb/ccd_readout_seq_tb.sv
module ccd_readout_seq_tb_top;
  localparam int ROW_W = 5;
  localparam int COL_W = 4;
  localparam int NTRK  = 3;
  localparam int GAP_W = 3;
  localparam int TW    = $clog2(NTRK + 1);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [1:0] mode = '0;
  logic [COL_W-1:0] width = '0;
  logic [ROW_W-1:0] height = '0, vbin = '0;
  logic [GAP_W-1:0] gap = '0;
  logic [TW-1:0] ntracks = '0;
  logic [NTRK*ROW_W-1:0] ts = '0, th = '0;
  logic vshift, hshift, convert, busy, done, cfg_err;
  logic [ROW_W-1:0] row_idx;
  logic [COL_W-1:0] col_idx;

  ccd_readout_seq #(.ROW_W(ROW_W), .COL_W(COL_W), .NTRK(NTRK), .GAP_W(GAP_W)) dut_i (
    .clk(clk), .rst(rst), .start_i(start), .cfg_mode_i(mode), .cfg_width_i(width),
    .cfg_height_i(height), .cfg_vbin_i(vbin), .cfg_gap_i(gap),
    .cfg_ntracks_i(ntracks), .trk_start_i(ts), .trk_height_i(th),
    .vshift_o(vshift), .hshift_o(hshift), .convert_o(convert),
    .row_idx_o(row_idx), .col_idx_o(col_idx), .busy_o(busy), .done_o(done),
    .cfg_err_o(cfg_err)
  );

  always #4 clk = ~clk;

  int checks = 0, errors = 0;
  int cyc = 0;
  int ngrp, gv[16], gh[16], gc[16];
  bit in_h;
  int nv, nh, nc, ndone, nobusy, col_bad, conv_bad, multi_hi;
  int last_t, last_k, min_sp;

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic clear_mon();
    ngrp = 0; in_h = 1'b1;
    for (int i = 0; i < 16; i++) begin gv[i] = 0; gh[i] = 0; gc[i] = 0; end
    nv = 0; nh = 0; nc = 0; ndone = 0; nobusy = 0; col_bad = 0; conv_bad = 0;
    multi_hi = 0; last_t = -1; last_k = 0; min_sp = 999;
  endtask

  always @(negedge clk) begin
    cyc++;
    if (vshift || hshift || convert) begin
      if (!busy) nobusy++;
      if (int'(vshift) + int'(hshift) + int'(convert) > 1) multi_hi++;
      if (last_t >= 0 && (cyc - last_t) < min_sp) min_sp = cyc - last_t;
      if (vshift) begin
        nv++;
        if (in_h) begin ngrp++; in_h = 1'b0; end
        if (ngrp > 0 && ngrp <= 16) gv[ngrp-1]++;
        last_k = 1;
      end
      if (hshift) begin
        nh++; in_h = 1'b1;
        if (ngrp > 0 && ngrp <= 16) begin
          if (int'(col_idx) != gh[ngrp-1]) col_bad++;
          gh[ngrp-1]++;
        end
        last_k = 2;
      end
      if (convert) begin
        nc++;
        if (last_k != 2 || (cyc - last_t) != int'(gap) + 1) conv_bad++;
        if (ngrp > 0 && ngrp <= 16) gc[ngrp-1]++;
        last_k = 3;
      end
      last_t = cyc;
    end
    if (done) ndone++;
  end

  initial begin
    #1500000;
    errors++; checks++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  task automatic pulse_start();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic run_and_wait(int extra_start_at);
    int n = 0;
    @(posedge clk); clear_mon();
    pulse_start();
    while (ndone == 0 && n < 4000) begin
      @(negedge clk); n++;
      if (n == extra_start_at) begin start = 1'b1; @(negedge clk); start = 1'b0; n++; end
    end
    repeat (3) @(negedge clk);
    chk("R9 run completes", int'(n < 4000), 1);
  endtask

  task automatic chk_grp(string req, int g, int v, int h, int c);
    chk({req, " group vshifts"}, gv[g], v);
    chk({req, " group hshifts"}, gh[g], h);
    chk({req, " group converts"}, gc[g], c);
  endtask

  task automatic chk_common(int exp_sp);
    chk("R2 column index order", col_bad, 0);
    chk("R3 convert placement", conv_bad, 0);
    chk("R4 one strobe per cycle", multi_hi, 0);
    chk("R4 minimum strobe spacing", min_sp, exp_sp);
    chk("R9 strobes only while busy", nobusy, 0);
    chk("R9 single done pulse", ndone, 1);
    chk("R9 busy low after done", int'(busy), 0);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R11 reset strobes", int'({vshift, hshift, convert}), 0);
    chk("R11 reset flags", int'({busy, done, cfg_err}), 0);
    chk("R11 reset indices", int'({row_idx, col_idx}), 0);
  endtask

  task automatic t_full();
    mode = 2'd0; height = 5'd7; vbin = 5'd3; width = 4'd5; gap = 3'd1;
    run_and_wait(0);
    chk("R1 line count", ngrp, 3);
    chk_grp("R1 line0", 0, 3, 5, 5);
    chk_grp("R1 line1", 1, 3, 5, 5);
    chk_grp("R1 partial last line", 2, 1, 5, 5);
    chk("R1 rows shifted", int'(row_idx), 7);
    chk_common(2);
    mode = 2'd0; height = 5'd4; vbin = 5'd2; width = 4'd3; gap = 3'd0;
    run_and_wait(0);
    chk("R1 gap0 line count", ngrp, 2);
    chk_grp("R1 gap0 line", 1, 2, 3, 3);
    chk_common(1);
  endtask

  task automatic t_single();
    mode = 2'd1; height = 5'd12; width = 4'd4; gap = 3'd2;
    ts = {5'd0, 5'd0, 5'd4}; th = {5'd0, 5'd0, 5'd3};
    run_and_wait(0);
    chk("R5 line count", ngrp, 2);
    chk_grp("R7 dump before track", 0, 4, 4, 0);
    chk_grp("R5 track line", 1, 3, 4, 4);
    chk("R5 rows shifted", int'(row_idx), 7);
    chk_common(3);
    ts = {5'd0, 5'd0, 5'd0}; th = {5'd0, 5'd0, 5'd5};
    run_and_wait(0);
    chk("R5 track at row0 no dump", ngrp, 1);
    chk_grp("R5 track at row0", 0, 5, 4, 4);
  endtask

  task automatic t_multi();
    mode = 2'd2; height = 5'd10; width = 4'd3; gap = 3'd1; ntracks = 2'd3;
    ts = {5'd9, 5'd6, 5'd2}; th = {5'd1, 5'd3, 5'd2};
    run_and_wait(0);
    chk("R6 segment count", ngrp, 5);
    chk_grp("R7 dump0", 0, 2, 3, 0);
    chk_grp("R6 track0", 1, 2, 3, 3);
    chk_grp("R7 dump1", 2, 2, 3, 0);
    chk_grp("R6 track1", 3, 3, 3, 3);
    chk_grp("R6 adjacent track2 no dump", 4, 1, 3, 3);
    chk("R6 rows shifted to last row", int'(row_idx), 10);
    chk_common(2);
  endtask

  task automatic t_fvb();
    mode = 2'd3; height = 5'd9; vbin = 5'd2; width = 4'd6; gap = 3'd1;
    run_and_wait(0);
    chk("R8 single line", ngrp, 1);
    chk_grp("R8 full column", 0, 9, 6, 6);
    chk("R8 row index", int'(row_idx), 9);
    chk_common(2);
  endtask

  task automatic t_err_one(string req);
    @(posedge clk); clear_mon();
    pulse_start();
    repeat (6) @(negedge clk);
    chk({req, " err flag"}, int'(cfg_err), 1);
    chk({req, " stays idle"}, int'(busy), 0);
    chk({req, " no strobes"}, nv + nh + nc + ndone, 0);
  endtask

  task automatic t_errors();
    mode = 2'd2; height = 5'd10; width = 4'd3; gap = 3'd0; ntracks = 2'd2;
    ts = {5'd0, 5'd4, 5'd2}; th = {5'd0, 5'd2, 5'd3};
    t_err_one("R10 overlap");
    mode = 2'd1; ts = {5'd0, 5'd0, 5'd8}; th = {5'd0, 5'd0, 5'd3};
    t_err_one("R10 past height");
    mode = 2'd2; ntracks = 2'd1; ts = {5'd0, 5'd0, 5'd2}; th = {5'd0, 5'd0, 5'd2};
    t_err_one("R10 too few tracks");
    mode = 2'd1; ts = {5'd0, 5'd0, 5'd7}; th = {5'd0, 5'd0, 5'd3};
    run_and_wait(0);
    chk("R10 valid start clears err", int'(cfg_err), 0);
    chk_grp("R5 track ends on last row", 1, 3, 3, 3);
  endtask

  task automatic t_busy_start();
    mode = 2'd1; height = 5'd12; width = 4'd4; gap = 3'd1;
    ts = {5'd0, 5'd0, 5'd4}; th = {5'd0, 5'd0, 5'd3};
    run_and_wait(20);
    chk("R9 start while busy ignored", ngrp, 2);
    chk("R9 start while busy hshifts", nh, 8);
    chk("R9 start while busy converts", nc, 4);
    chk_common(2);
  endtask

  initial begin
    clear_mon();
    repeat (4) @(posedge clk);
    rst = 1'b0;
    t_reset();
    t_full();
    t_single();
    t_multi();
    t_fvb();
    t_errors();
    t_busy_start();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule